// File: doc/BRIEF.md
# Infrared Receiver Edge Capture Unit

This block sits behind the pin that carries the demodulated output of an infrared remote-control receiver. It brings the asynchronous pin into the core clock domain and filters it at the rate of a slow reference tick. The tick comes from a 32.768 kHz or 75 kHz source and is one core clock wide. A new level is believed only when it has been seen on three sample ticks in a row, so short glitches are dropped.

A free-running 8-bit counter advances on the same tick. When the filtered level changes and the edge type is enabled, the counter value is latched. Rising edges go into one holding register and falling edges into another. Software can then take the difference between a pair of captures to measure mark and space widths. Each accepted edge raises a one-cycle interrupt pulse. Each holding register has a valid flag and an overrun flag. Both flags are cleared by a read strobe.

Top module: `ir_edge_capture`

## Requirements
- R1: The pin passes through a two-stage synchroniser and is then sampled only on tick cycles. The filtered level becomes a new value only on the tick at which the last three samples all equal that value. A pulse seen on fewer than three consecutive ticks produces no edge, no capture and no interrupt.
- R2: The 8-bit counter starts at 0, adds one on every tick cycle and wraps from 255 to 0. A capture stores the number of ticks since reset, modulo 256, counted up to and including the tick that accepted the edge.
- R3: `edge_sel_i` bit 0 enables rising edges. When this bit is 1, an accepted low-to-high change stores the counter in `rise_val_o`.
- R4: `edge_sel_i` bit 1 enables falling edges. When this bit is 1, an accepted high-to-low change stores the counter in `fall_val_o`. Setting both bits captures both kinds of edge.
- R5: An edge whose enable bit is 0 leaves the value, valid flag and overrun flag of its register unchanged, and it raises no interrupt.
- R6: `irq_o` is high for exactly one clock per captured edge. It is high in the clock after the accepting tick, which is the same clock in which the value and valid flag first show the capture.
- R7: A capture sets the valid flag of its register. The read strobe of that register clears the flag. A capture in the same cycle as a read leaves the flag set and raises no overrun.
- R8: A capture that arrives while the valid flag is set and no read is active sets the overrun flag and replaces the value with the newer one. The read strobe clears the overrun flag.
- R9: While `rst` is high, both values, all four flags and `irq_o` are 0, the counter is 0, and the filtered level is high (idle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle strobe from the low-speed reference clock |
| pin_i | input | 1 | Asynchronous receiver pin |
| edge_sel_i | input | 2 | Bit 0 enables rising edges, bit 1 enables falling edges |
| rd_rise_i | input | 1 | Read strobe for the rising-edge register |
| rd_fall_i | input | 1 | Read strobe for the falling-edge register |
| rise_val_o | output | 8 | Counter value at the last rising capture |
| fall_val_o | output | 8 | Counter value at the last falling capture |
| rise_vld_o | output | 1 | Rising-edge register holds an unread capture |
| fall_vld_o | output | 1 | Falling-edge register holds an unread capture |
| rise_ovr_o | output | 1 | A rising capture overwrote an unread one |
| fall_ovr_o | output | 1 | A falling capture overwrote an unread one |
| irq_o | output | 1 | One-cycle pulse per captured edge |

## Verification
The hardest case to reach is a read strobe that lands in exactly the cycle in which a capture is written. The capture cycle depends on the synchroniser delay, the tick phase and the three-sample filter, so a fixed delay after the pin change would hit it only by chance. The bench therefore steps its own behavioural model one cycle ahead. As soon as the model shows that the filter has accepted an edge, the bench raises the read strobe for the following clock. Glitches of one and two samples are also driven, and a long run with a tick on every cycle is used so that a capture is taken after the counter has wrapped.

// File: rtl/ircap_pkg.sv
package ircap_pkg;
  localparam int SEL_RISE_BIT = 0;
  localparam int SEL_FALL_BIT = 1;
  localparam int NUM_EDGE     = 2;

  typedef struct packed {
    logic fall;
    logic rise;
  } edge_pair_t;
endpackage

// File: rtl/ircap_sync.sv
module ircap_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= {STAGES{IDLE}};
    else     sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/ircap_filter.sv
module ircap_filter #(
  parameter int   SAMPLES = 3,
  parameter logic IDLE    = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick_i,
  input  logic                  din_i,
  output logic                  level_o,
  output ircap_pkg::edge_pair_t edge_o
);
  localparam int HW = SAMPLES - 1;

  logic [HW-1:0]      hist_q;
  logic [SAMPLES-1:0] win;
  logic               all_hi, all_lo;

  assign win    = {hist_q, din_i};
  assign all_hi = &win;
  assign all_lo = ~|win;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q  <= {HW{IDLE}};
      level_o <= IDLE;
      edge_o  <= '0;
    end else begin
      edge_o <= '0;
      if (tick_i) begin
        hist_q <= win[HW-1:0];
        if (all_hi && !level_o) begin
          level_o     <= 1'b1;
          edge_o.rise <= 1'b1;
        end else if (all_lo && level_o) begin
          level_o     <= 1'b0;
          edge_o.fall <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ircap_counter.sv
module ircap_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst)         cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ircap_channel.sv
module ircap_channel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hit_i,
  input  logic [W-1:0] cnt_i,
  input  logic         rd_i,
  output logic [W-1:0] val_o,
  output logic         vld_o,
  output logic         ovr_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      val_o <= '0;
      vld_o <= 1'b0;
      ovr_o <= 1'b0;
    end else if (hit_i) begin
      val_o <= cnt_i;
      vld_o <= 1'b1;
      ovr_o <= (vld_o | ovr_o) & ~rd_i;
    end else if (rd_i) begin
      vld_o <= 1'b0;
      ovr_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ir_edge_capture.sv
module ir_edge_capture #(
  parameter int   CNT_W       = 8,
  parameter int   SYNC_STAGES = 2,
  parameter int   SAMPLES     = 3,
  parameter logic IDLE        = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             pin_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             rd_rise_i,
  input  logic             rd_fall_i,
  output logic [CNT_W-1:0] rise_val_o,
  output logic [CNT_W-1:0] fall_val_o,
  output logic             rise_vld_o,
  output logic             fall_vld_o,
  output logic             rise_ovr_o,
  output logic             fall_ovr_o,
  output logic             irq_o
);
  import ircap_pkg::*;

  logic                 pin_s;
  logic                 filt_level;
  edge_pair_t           edg;
  logic [CNT_W-1:0]     cnt_q;
  logic [NUM_EDGE-1:0]  hit;
  logic [NUM_EDGE-1:0]  rd;
  logic [CNT_W-1:0]     ch_val [NUM_EDGE];
  logic [NUM_EDGE-1:0]  ch_vld;
  logic [NUM_EDGE-1:0]  ch_ovr;

  ircap_sync #(.STAGES(SYNC_STAGES), .IDLE(IDLE)) u_sync (
    .clk(clk), .rst(rst), .d_i(pin_i), .q_o(pin_s)
  );

  ircap_filter #(.SAMPLES(SAMPLES), .IDLE(IDLE)) u_filt (
    .clk(clk), .rst(rst), .tick_i(tick_i), .din_i(pin_s),
    .level_o(filt_level), .edge_o(edg)
  );

  ircap_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick_i), .cnt_o(cnt_q)
  );

  assign hit[SEL_RISE_BIT] = edg.rise & edge_sel_i[SEL_RISE_BIT];
  assign hit[SEL_FALL_BIT] = edg.fall & edge_sel_i[SEL_FALL_BIT];
  assign rd[SEL_RISE_BIT]  = rd_rise_i;
  assign rd[SEL_FALL_BIT]  = rd_fall_i;

  for (genvar g = 0; g < NUM_EDGE; g++) begin : g_ch
    ircap_channel #(.W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .hit_i(hit[g]), .cnt_i(cnt_q), .rd_i(rd[g]),
      .val_o(ch_val[g]), .vld_o(ch_vld[g]), .ovr_o(ch_ovr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |hit;
  end

  assign rise_val_o = ch_val[SEL_RISE_BIT];
  assign fall_val_o = ch_val[SEL_FALL_BIT];
  assign rise_vld_o = ch_vld[SEL_RISE_BIT];
  assign fall_vld_o = ch_vld[SEL_FALL_BIT];
  assign rise_ovr_o = ch_ovr[SEL_RISE_BIT];
  assign fall_ovr_o = ch_ovr[SEL_FALL_BIT];
endmodule

// File: rtl/ir_edge_capture_chk.sv
module ir_edge_capture_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_i,
  input logic [1:0]       edge_sel_i,
  input logic             rd_rise_i,
  input logic             rd_fall_i,
  input logic             rise_vld_o,
  input logic             fall_vld_o,
  input logic             rise_ovr_o,
  input logic             fall_ovr_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt,
  input logic             level
);
  // R1
  filt_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(level));
  // R2
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && cnt == {CNT_W{1'b1}}) |=> cnt == '0);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(cnt));
  // R5
  rise_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rise_vld_o) |-> $past(edge_sel_i[0]));
  // R5
  fall_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fall_vld_o) |-> $past(edge_sel_i[1]));
  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);
  // R6
  irq_vld_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (rise_vld_o || fall_vld_o));
  // R7
  rise_rd_chk: assert property (@(posedge clk) disable iff (rst)
    rd_rise_i |=> !rise_ovr_o);
  // R7
  fall_rd_chk: assert property (@(posedge clk) disable iff (rst)
    rd_fall_i |=> !fall_ovr_o);
  // R8
  rise_ovr_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rise_ovr_o) |-> (rise_vld_o && $past(rise_vld_o)));
  // R8
  fall_ovr_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fall_ovr_o) |-> (fall_vld_o && $past(fall_vld_o)));
endmodule

bind ir_edge_capture ir_edge_capture_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .edge_sel_i(edge_sel_i),
  .rd_rise_i(rd_rise_i), .rd_fall_i(rd_fall_i),
  .rise_vld_o(rise_vld_o), .fall_vld_o(fall_vld_o),
  .rise_ovr_o(rise_ovr_o), .fall_ovr_o(fall_ovr_o), .irq_o(irq_o),
  .cnt(cnt_q), .level(filt_level)
);

// File: tb/test_ir_edge_capture.sv
module test_ir_edge_capture;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       pin = 1'b1;
  logic [1:0] sel = 2'b11;
  logic       rd_r = 1'b0;
  logic       rd_f = 1'b0;
  logic [7:0] rise_val, fall_val;
  logic       rise_vld, fall_vld, rise_ovr, fall_ovr, irq;

  int checks = 0;
  int fails  = 0;
  int gap    = 3;
  int gcnt   = 0;
  int irq_seen = 0;
  bit cmp_en = 0;
  bit done   = 0;

  // behavioural reference model state
  int m_s1, m_s2, m_lvl, m_last, m_run, m_rp, m_fp, m_cnt;
  int m_rv, m_fv, m_rvl, m_fvl, m_ro, m_fo, m_irq, m_irq_n;

  always #4 clk = ~clk;

  ir_edge_capture i_ir_edge_capture (
    .clk(clk), .rst(rst), .tick_i(tick), .pin_i(pin), .edge_sel_i(sel),
    .rd_rise_i(rd_r), .rd_fall_i(rd_f),
    .rise_val_o(rise_val), .fall_val_o(fall_val),
    .rise_vld_o(rise_vld), .fall_vld_o(fall_vld),
    .rise_ovr_o(rise_ovr), .fall_ovr_o(fall_ovr), .irq_o(irq)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 1; m_s2 = 1; m_lvl = 1; m_last = 1; m_run = 2;
      m_rp = 0; m_fp = 0; m_cnt = 0;
      m_rv = 0; m_fv = 0; m_rvl = 0; m_fvl = 0; m_ro = 0; m_fo = 0;
      m_irq = 0; m_irq_n = 0;
    end else begin
      int hr, hf, nrp, nfp;
      hr = m_rp & int'(sel[0]);
      hf = m_fp & int'(sel[1]);
      m_irq = hr | hf;
      if (m_irq) m_irq_n++;
      if (hr) begin
        m_ro = (m_rvl | m_ro) & int'(!rd_r); m_rvl = 1; m_rv = m_cnt;
      end else if (rd_r) begin
        m_rvl = 0; m_ro = 0;
      end
      if (hf) begin
        m_fo = (m_fvl | m_fo) & int'(!rd_f); m_fvl = 1; m_fv = m_cnt;
      end else if (rd_f) begin
        m_fvl = 0; m_fo = 0;
      end
      nrp = 0; nfp = 0;
      if (tick) begin
        if (m_s2 == m_last) m_run++;
        else begin m_run = 1; m_last = m_s2; end
        if (m_run >= 3 && m_s2 != m_lvl) begin
          if (m_s2 == 1) nrp = 1; else nfp = 1;
          m_lvl = m_s2;
        end
        m_cnt = (m_cnt + 1) % 256;
      end
      m_rp = nrp; m_fp = nfp;
      m_s2 = m_s1; m_s1 = int'(pin);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    if (irq) irq_seen++;
    if (cmp_en) begin
      chk("R6 irq", int'(irq), m_irq);
      chk("R3 rise_val", int'(rise_val), m_rv);
      chk("R4 fall_val", int'(fall_val), m_fv);
      chk("R7 rise_vld", int'(rise_vld), m_rvl);
      chk("R7 fall_vld", int'(fall_vld), m_fvl);
      chk("R8 rise_ovr", int'(rise_ovr), m_ro);
      chk("R8 fall_ovr", int'(fall_ovr), m_fo);
    end
    tick = (gcnt == 0);
    gcnt = (gcnt >= gap) ? 0 : gcnt + 1;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic rd_both();
    rd_r = 1'b1; rd_f = 1'b1; cyc(); rd_r = 1'b0; rd_f = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    run(4);
    // R9: reset state
    chk("R9 rise_val", int'(rise_val), 0);
    chk("R9 vld flags", int'({rise_vld, fall_vld}), 0);
    chk("R9 ovr flags", int'({rise_ovr, fall_ovr}), 0);
    chk("R9 irq", int'(irq), 0);
    rst = 1'b0;
    cmp_en = 1;
    run(30);

    // R1: short low glitch (at most two samples) is rejected
    pin = 1'b0; run(5); pin = 1'b1; run(40);
    chk("R1 glitch no fall capture", int'(fall_vld), 0);
    chk("R1 glitch no irq", irq_seen, 0);

    // R4 then R3: falling and rising captures with both enabled
    pin = 1'b0; run(40);
    chk("R4 fall captured", int'(fall_vld), 1);
    chk("R4 fall value", int'(fall_val), m_fv);
    pin = 1'b1; run(40);
    chk("R3 rise captured", int'(rise_vld), 1);
    chk("R6 one irq per edge", irq_seen, 2);
    rd_both(); run(2);
    chk("R7 read clears valid", int'({rise_vld, fall_vld}), 0);

    // R5: rising only; falling edge ignored
    sel = 2'b01;
    pin = 1'b0; run(40);
    chk("R5 unselected fall no valid", int'(fall_vld), 0);
    chk("R5 unselected fall no irq", irq_seen, 2);
    pin = 1'b1; run(40);
    chk("R3 rise-only capture", int'(rise_vld), 1);

    // R8: second rising capture without a read
    pin = 1'b0; run(40); pin = 1'b1; run(40);
    chk("R8 overrun set", int'(rise_ovr), 1);
    chk("R8 newest value kept", int'(rise_val), m_rv);
    rd_both(); run(2);
    chk("R8 read clears overrun", int'({rise_ovr, rise_vld}), 0);

    // R7: leave a capture pending, then read exactly in the capture cycle
    pin = 1'b0; run(40); pin = 1'b1; run(40);
    pin = 1'b0; run(40); pin = 1'b1;
    for (int i = 0; i < 60; i++) begin
      cyc();
      if (m_rp != 0) begin
        rd_r = 1'b1; cyc(); rd_r = 1'b0;
        break;
      end
    end
    run(2);
    chk("R7 capture with read valid", int'(rise_vld), 1);
    chk("R7 capture with read no ovr", int'(rise_ovr), 0);
    rd_both(); run(2);

    // R5: nothing selected
    sel = 2'b00;
    pin = 1'b0; run(40); pin = 1'b1; run(40);
    chk("R5 none selected no capture", int'({rise_vld, fall_vld}), 0);

    // R2: tick every cycle, wrap the counter before capturing
    sel = 2'b10; gap = 0;
    run(300);
    pin = 1'b0; run(10);
    chk("R2 value after wrap", int'(fall_val), m_fv);
    chk("R2 fall captured after wrap", int'(fall_vld), 1);
    pin = 1'b1; run(10);
    chk("R6 irq total vs model", irq_seen, m_irq_n);

    done = 1;
    summary();
    $finish;
  end
endmodule